// File: doc/BRIEF.md
# CAN Controller Status Word and Buffer Handshake

This block holds the 8-bit status word of a CAN controller. It also keeps the handshake state between the CPU and the controller's transmit buffer and two-deep receive buffer. The CPU sees the word on a read-only output. It acts on the block through three single-cycle command pulses: request a transmission, release a receive buffer, and clear the overrun flag.

The protocol engine reports activity through single-cycle event pulses: transmission start and finish, reception start and finish, and the first byte of a new incoming message. It also drives its transmit and receive error counters and a bus-off flag. Bus status and error status follow their inputs combinationally. Every other bit is a register that changes on the clock edge after the pulse that causes it.

Top module: `can_status_word`

## Requirements
- R1: After reset the status word reads 0x0C. That is: bus-on, no error, both directions idle, transmission complete (bit 3) = 1, transmit buffer released (bit 2) = 1, no overrun, receive buffer empty.
- R2: Bit 7 (bus status) equals the bus-off input in the same cycle.
- R3: Bit 6 (error status) is 1 when either error counter is greater than or equal to WARN_LIMIT (default 96). It is 0 when both counters are below it.
- R4: Bit 5 (transmitting) goes to 1 on a transmit-start event and to 0 on a transmit-done event. Bit 4 (receiving) behaves the same way for the receive-start and receive-done events.
- R5: An accepted transmit request clears bit 3 and bit 2 on the next edge. A transmit-done event sets both bits again.
- R6: A transmit request that arrives while bit 2 is 0 is ignored, and the status word is unchanged.
- R7: Each completed reception, while fewer than two buffers are held, adds one held message and sets bit 0. Each release command removes one held message. Bit 0 stays 1 until no message is held.
- R8: Bit 1 (overrun) is set only by a first-byte event that arrives while two messages are held. That message is discarded and is not counted. A first-byte event with one message held leaves bit 1 at 0.
- R9: Bit 1 stays set through any other activity until a clear-overrun command clears it on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_tx_req | input | 1 | CPU transmit request pulse |
| cmd_rx_release | input | 1 | CPU release-receive-buffer pulse |
| cmd_ovr_clear | input | 1 | CPU clear-overrun pulse |
| ev_tx_start | input | 1 | Engine: transmission begins |
| ev_tx_done | input | 1 | Engine: transmission finished successfully |
| ev_rx_start | input | 1 | Engine: reception begins |
| ev_rx_done | input | 1 | Engine: reception finished |
| ev_rx_first | input | 1 | Engine: first byte of a new message to be stored |
| tx_errs | input | 8 | Transmit error counter |
| rx_errs | input | 8 | Receive error counter |
| bus_off | input | 1 | Engine is bus-off |
| status | output | 8 | Status word: {bus, err, tx, rx, tx_cmpl, tx_free, ovr, rx_full} |

## Verification
A wrong held-message count does not show at once. It shows up only after one or two releases, when bit 0 falls too early or too late, or when a first-byte event sets or misses bit 1. The bench therefore drains the buffer after each fill and watches the word after each release. A stuck transmit lock shows on the very next edge as bit 2 staying low after a done event. A lost overrun shows one cycle after the first-byte event.

// File: rtl/can_status_word.sv
module can_status_word #(
  parameter int ERR_W      = 8,
  parameter int WARN_LIMIT = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_tx_req,
  input  logic             cmd_rx_release,
  input  logic             cmd_ovr_clear,
  input  logic             ev_tx_start,
  input  logic             ev_tx_done,
  input  logic             ev_rx_start,
  input  logic             ev_rx_done,
  input  logic             ev_rx_first,
  input  logic [ERR_W-1:0] tx_errs,
  input  logic [ERR_W-1:0] rx_errs,
  input  logic             bus_off,
  output logic [7:0]       status
);
  localparam logic [ERR_W-1:0] LIM = ERR_W'(WARN_LIMIT);

  logic       tx_busy, rx_busy, tx_cmpl, tx_lock, ovr, drop;
  logic [1:0] held;

  wire err_warn = (tx_errs >= LIM) || (rx_errs >= LIM);
  wire full     = (held == 2'd2);
  wire take     = ev_rx_done && !drop && !full;
  wire give     = cmd_rx_release && (held != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      rx_busy <= 1'b0;
      tx_cmpl <= 1'b1;
      tx_lock <= 1'b0;
      ovr     <= 1'b0;
      drop    <= 1'b0;
      held    <= 2'd0;
    end else begin
      if (ev_tx_done)       tx_busy <= 1'b0;
      else if (ev_tx_start) tx_busy <= 1'b1;
      if (ev_rx_done)       rx_busy <= 1'b0;
      else if (ev_rx_start) rx_busy <= 1'b1;

      if (tx_lock && ev_tx_done) begin
        tx_lock <= 1'b0;
        tx_cmpl <= 1'b1;
      end else if (!tx_lock && cmd_tx_req) begin
        tx_lock <= 1'b1;
        tx_cmpl <= 1'b0;
      end

      if (ev_rx_first && full) ovr <= 1'b1;
      else if (cmd_ovr_clear)  ovr <= 1'b0;

      if (ev_rx_done)               drop <= 1'b0;
      else if (ev_rx_first && full) drop <= 1'b1;

      case ({take, give})
        2'b10:   held <= held + 2'd1;
        2'b01:   held <= held - 2'd1;
        default: held <= held;
      endcase
    end
  end

  assign status = {bus_off, err_warn, tx_busy, rx_busy, tx_cmpl, !tx_lock, ovr, held != 2'd0};

  AST_TCS_LOW_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !status[2] |-> !status[3]);  // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[2] && !ev_tx_done) |=> !status[2]);  // R6
  AST_RBS_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cmd_rx_release) |=> status[0]);  // R7
  AST_HELD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    held <= 2'd2);  // R7
  AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[1] && !(ev_rx_first && full)) |=> !status[1]);  // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !cmd_ovr_clear) |=> status[1]);  // R9
endmodule

// File: tb/tb_can_status_word.sv
module tb_can_status_word;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] p = 8'h00;
  logic [7:0] tx_errs = 8'd0, rx_errs = 8'd0;
  logic       bus_off = 1'b0;
  logic [7:0] status;
  int nchk = 0, nfail = 0;
  bit done = 0;

  localparam int TXREQ = 0, REL = 1, CLR = 2, TXS = 3, TXD = 4, RXS = 5, RXD = 6, FIRST = 7;

  always #4 clk = ~clk;

  can_status_word dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_tx_req(p[TXREQ]), .cmd_rx_release(p[REL]), .cmd_ovr_clear(p[CLR]),
    .ev_tx_start(p[TXS]), .ev_tx_done(p[TXD]), .ev_rx_start(p[RXS]),
    .ev_rx_done(p[RXD]), .ev_rx_first(p[FIRST]),
    .tx_errs(tx_errs), .rx_errs(rx_errs), .bus_off(bus_off), .status(status));

  task automatic chk(input string req, input logic [7:0] exp);
    nchk++;
    if (status !== exp) begin
      nfail++;
      $display("FAIL %s: status=%h expected=%h", req, status, exp);
    end
  endtask

  task automatic pulse(input int i);
    @(negedge clk) p[i] = 1'b1;
    @(negedge clk) p = 8'h00;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", 8'h0C);
  endtask

  task automatic t_bus;
    bus_off = 1'b1; #1; chk("R2 bus-off", 8'h8C);
    bus_off = 1'b0; #1; chk("R2 bus-on", 8'h0C);
  endtask

  task automatic t_err;
    tx_errs = 8'd95; #1; chk("R3 tx below limit", 8'h0C);
    tx_errs = 8'd96; #1; chk("R3 tx at limit", 8'h4C);
    tx_errs = 8'd0; rx_errs = 8'd200; #1; chk("R3 rx above limit", 8'h4C);
    rx_errs = 8'd0; #1; chk("R3 both low", 8'h0C);
  endtask

  task automatic t_tx;
    pulse(TXREQ); chk("R5 request locks", 8'h00);
    pulse(TXS);   chk("R4 tx start", 8'h20);
    pulse(TXREQ); chk("R6 request while locked", 8'h20);
    pulse(TXD);   chk("R5 done releases", 8'h0C);
    pulse(RXS);   chk("R4 rx start", 8'h1C);
    pulse(RXD);   chk("R7 first message held", 8'h0D);
  endtask

  task automatic t_rx;
    pulse(RXD);   chk("R7 two held", 8'h0D);
    pulse(FIRST); chk("R8 full then first byte", 8'h0F);
    pulse(RXD);   chk("R8 discarded message", 8'h0F);
    pulse(REL);   chk("R7 one left", 8'h0F);
    pulse(TXREQ); chk("R9 sticky over tx", 8'h03);
    pulse(TXD);   chk("R9 sticky after tx", 8'h0F);
    pulse(REL);   chk("R8 discarded not counted", 8'h0E);
    pulse(CLR);   chk("R9 clear", 8'h0C);
    pulse(RXD);   chk("R7 refill", 8'h0D);
    pulse(FIRST); chk("R8 no overrun with one held", 8'h0D);
    pulse(RXD);   chk("R7 second held", 8'h0D);
    pulse(REL);   chk("R7 release one", 8'h0D);
    pulse(REL);   chk("R7 empty", 8'h0C);
    pulse(REL);   chk("R7 release when empty", 8'h0C);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    nchk++; nfail++;
    $display("FAIL watchdog: status=%h expected=done", status);
    finish_run();
  end

  initial begin
    t_reset();
    t_bus();
    t_err();
    t_tx();
    t_rx();
    finish_run();
  end
endmodule